// File: doc/BRIEF.md
# Scratchpad RAM Window with Tag-Port Configuration

This block is one local RAM region that sits next to a data cache. The load/store pipeline presents physical addresses to it. When the region is enabled and an address falls inside its window, the block claims the access, reports a hit and gives the local word index. Stores that hit write the RAM. Loads that hit return data one cycle later.

Software does not find or place the region through memory-mapped registers. It uses the cache-tag diagnostic path instead. While a diagnostic mode input is high, tag reads and tag writes are routed to two configuration words held by this block:

- At index 0 is the base word. It holds the physical base page number and the enable flag.
- At index 8 is the size word. It holds the region length in 4 KB pages. That length is fixed by a parameter.

While diagnostic mode is low, tag operations are left for the ordinary cache tags and this block ignores them. After reset the region is disabled, so it is invisible until software sets the enable flag.

Top module: `spram_top`

## Requirements
- R1: After reset the enable flag is 0 and the base page is 0. A base-word read then returns 0x00000000, and a size-word read returns SIZE_PAGES in bits [31:12] with every other bit 0. Read as a 32-bit value, the size word equals the region size in bytes.
- R2: While `diag_mode` is 0, `tag_claim` stays 0, `tag_rdata` keeps its value, and tag writes change neither the enable flag nor the base.
- R3: With `diag_mode` at 1, a tag read at index 0 loads `tag_rdata` on the next clock edge. The value is the base page in bits [31:12], the enable flag in bit 7, and 0 in bits [11:8], bit 6 and bits [5:0].
- R4: With `diag_mode` at 1, a tag read at index 8 loads `tag_rdata` on the next clock edge. The value is SIZE_PAGES in bits [31:12] and the enable flag in bit 7, with all other bits 0.
- R5: With `diag_mode` at 1, a tag read at any index other than 0 and 8 loads `tag_rdata` with 0.
- R6: A tag write at index 0 with `diag_mode` at 1 sets the enable flag from `tag_wdata[7]`. It sets the base page from `tag_wdata[31:12]`, with the page bits below log2(SIZE_PAGES) cleared so that the base stays aligned to the region size.
- R7: A tag write at index 8 with `diag_mode` at 1 updates only the enable flag, from bit 7. The size field reads back unchanged whatever value is written to it.
- R8: While the enable flag is 0, `acc_hit` is 0 for every address.
- R9: While the enable flag is 1, `acc_hit` is 1 exactly when the page `acc_addr[31:12]` is at or above the base page and below the base page plus SIZE_PAGES. `acc_word` equals (acc_addr - base address) / 4. Both outputs are combinational in the same cycle.
- R10: A store (`acc_valid`, `acc_we`) that hits writes `acc_wdata` to the RAM word at `acc_word`. A load that hits puts that word on `acc_rdata` after the next clock edge. A store that misses leaves the RAM unchanged.
- R11: A tag write at any index other than 0 and 8 changes neither the enable flag nor the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_mode | input | 1 | Routes tag operations to this block when 1 |
| tag_rd | input | 1 | Tag read request |
| tag_wr | input | 1 | Tag write request |
| tag_index | input | 8 | Tag byte index (0 = base word, 8 = size word) |
| tag_wdata | input | 32 | Tag write value |
| tag_rdata | output | 32 | Registered tag read value |
| tag_claim | output | 1 | This block owns the current tag operation |
| acc_valid | input | 1 | Load/store access valid |
| acc_we | input | 1 | Access is a store |
| acc_addr | input | 32 | Physical byte address |
| acc_wdata | input | 32 | Store data |
| acc_hit | output | 1 | Address falls inside the enabled window |
| acc_word | output | AW | Local word index inside the region |
| acc_rdata | output | 32 | Load data, one cycle after a load hit |

## Verification
The window decode is tried with addresses one word below the base, at the first and last word of the region, one byte past the end, and in the middle of the region. These show whether each bound is inclusive or exclusive and whether the word index is computed correctly. The base is written with a misaligned page number so that the stored value shows the alignment masking. The size word is written with all ones to show that it cannot be changed. A store that misses is sent to an address whose low bits alias a live word. Reading that word afterwards shows whether stores are gated by the hit. Configuration traffic is also repeated with diagnostic mode low, to tell blocked operations apart from claimed ones.

// File: rtl/spram_pkg.sv
package spram_pkg;
    localparam int            TAG_IDX_W   = 8;
    localparam logic [7:0]    IDX_BASE    = 8'h00;
    localparam logic [7:0]    IDX_SIZE    = 8'h08;
    localparam int            EN_BIT      = 7;
    localparam int            PAGE_SHIFT  = 12;
    localparam int            PAGE_W      = 32 - PAGE_SHIFT;

    typedef struct packed {
        logic              en;
        logic [PAGE_W-1:0] base;
        logic [31:0]       rdata;
    } cfg_state_t;
endpackage

// File: rtl/spram_cfg_regs.sv
module spram_cfg_regs
    import spram_pkg::*;
#(
    parameter int SIZE_PAGES = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 diag_mode,
    input  logic                 tag_rd,
    input  logic                 tag_wr,
    input  logic [TAG_IDX_W-1:0] tag_index,
    input  logic [31:0]          tag_wdata,
    output logic [31:0]          tag_rdata,
    output logic                 tag_claim,
    output logic                 en,
    output logic [PAGE_W-1:0]    base
);
    localparam logic [PAGE_W-1:0] SIZE_FIELD = PAGE_W'(SIZE_PAGES);
    localparam logic [PAGE_W-1:0] BASE_MASK  = ~PAGE_W'(SIZE_PAGES - 1);

    cfg_state_t  s_d, s_q;
    logic [31:0] base_word, size_word;

    always_comb begin
        s_d       = s_q;
        base_word = {s_q.base, 4'b0, s_q.en, 7'b0};
        size_word = {SIZE_FIELD, 4'b0, s_q.en, 7'b0};
        if (diag_mode && tag_rd) begin
            case (tag_index)
                IDX_BASE: s_d.rdata = base_word;
                IDX_SIZE: s_d.rdata = size_word;
                default:  s_d.rdata = '0;
            endcase
        end
        if (diag_mode && tag_wr) begin
            case (tag_index)
                IDX_BASE: begin
                    s_d.base = tag_wdata[31:PAGE_SHIFT] & BASE_MASK;
                    s_d.en   = tag_wdata[EN_BIT];
                end
                IDX_SIZE: s_d.en = tag_wdata[EN_BIT];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tag_rdata = s_q.rdata;
    assign tag_claim = diag_mode && (tag_rd || tag_wr);
    assign en        = s_q.en;
    assign base      = s_q.base;
endmodule

// File: rtl/spram_window_decode.sv
module spram_window_decode
    import spram_pkg::*;
#(
    parameter int SIZE_PAGES = 1,
    parameter int AW         = 10
) (
    input  logic              en,
    input  logic [PAGE_W-1:0] base,
    input  logic [31:0]       addr,
    output logic              hit,
    output logic [AW-1:0]     word
);
    logic [PAGE_W:0]   limit;
    logic [PAGE_W-1:0] page;
    logic [31:0]       offs;

    always_comb begin
        page  = addr[31:PAGE_SHIFT];
        limit = {1'b0, base} + (PAGE_W+1)'(SIZE_PAGES);
        hit   = en && (page >= base) && ({1'b0, page} < limit);
        offs  = addr - {base, {PAGE_SHIFT{1'b0}}};
        word  = offs[AW+1:2];
    end
endmodule

// File: rtl/spram_array.sv
module spram_array #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[addr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) rdata_d = mem_q[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/spram_top.sv
module spram_top
    import spram_pkg::*;
#(
    parameter int SIZE_PAGES = 1,
    parameter int AW         = $clog2(SIZE_PAGES * 1024)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 diag_mode,
    input  logic                 tag_rd,
    input  logic                 tag_wr,
    input  logic [TAG_IDX_W-1:0] tag_index,
    input  logic [31:0]          tag_wdata,
    output logic [31:0]          tag_rdata,
    output logic                 tag_claim,
    input  logic                 acc_valid,
    input  logic                 acc_we,
    input  logic [31:0]          acc_addr,
    input  logic [31:0]          acc_wdata,
    output logic                 acc_hit,
    output logic [AW-1:0]        acc_word,
    output logic [31:0]          acc_rdata
);
    logic              cfg_en;
    logic [PAGE_W-1:0] cfg_base;
    logic              ram_rd, ram_wr;

    spram_cfg_regs #(.SIZE_PAGES(SIZE_PAGES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .diag_mode(diag_mode),
        .tag_rd(tag_rd), .tag_wr(tag_wr), .tag_index(tag_index),
        .tag_wdata(tag_wdata), .tag_rdata(tag_rdata), .tag_claim(tag_claim),
        .en(cfg_en), .base(cfg_base)
    );

    spram_window_decode #(.SIZE_PAGES(SIZE_PAGES), .AW(AW)) u_dec (
        .en(cfg_en), .base(cfg_base), .addr(acc_addr),
        .hit(acc_hit), .word(acc_word)
    );

    assign ram_rd = acc_valid && !acc_we && acc_hit;
    assign ram_wr = acc_valid &&  acc_we && acc_hit;

    spram_array #(.AW(AW), .DW(32)) u_ram (
        .clk(clk), .rst_n(rst_n), .rd_en(ram_rd), .wr_en(ram_wr),
        .addr(acc_word), .wdata(acc_wdata), .rdata(acc_rdata)
    );
endmodule

// File: rtl/spram_top_chk.sv
module spram_top_chk
    import spram_pkg::*;
#(
    parameter int SIZE_PAGES = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 diag_mode,
    input logic                 tag_rd,
    input logic                 tag_wr,
    input logic [TAG_IDX_W-1:0] tag_index,
    input logic [31:0]          tag_rdata,
    input logic                 acc_hit,
    input logic [31:0]          acc_addr,
    input logic                 cfg_en,
    input logic [PAGE_W-1:0]    cfg_base
);
    localparam logic [PAGE_W-1:0] LOW_MASK = ~PAGE_W'(SIZE_PAGES - 1);

    assert_no_hit_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !acc_hit);

    assert_tag_read_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_rd && !diag_mode) |=> $stable(tag_rdata));

    assert_cfg_write_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_mode |=> ($stable(cfg_en) && $stable(cfg_base)));

    assert_size_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_mode && tag_rd && tag_index == IDX_SIZE)
        |=> tag_rdata[31:PAGE_SHIFT] == PAGE_W'(SIZE_PAGES));

    assert_other_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_mode && tag_rd && tag_index != IDX_BASE && tag_index != IDX_SIZE)
        |=> tag_rdata == 32'h0);

    assert_hit_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |-> ((acc_addr[31:PAGE_SHIFT] & LOW_MASK) == cfg_base));
endmodule

bind spram_top spram_top_chk #(.SIZE_PAGES(SIZE_PAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .diag_mode(diag_mode), .tag_rd(tag_rd),
    .tag_wr(tag_wr), .tag_index(tag_index), .tag_rdata(tag_rdata),
    .acc_hit(acc_hit), .acc_addr(acc_addr), .cfg_en(cfg_en), .cfg_base(cfg_base)
);

// File: tb/spram_top_tb.sv
module spram_top_tb;
    localparam int CLK_P = 10;
    localparam int PAGES = 2;
    localparam int AW    = $clog2(PAGES * 1024);
    localparam logic [31:0] BASE = 32'h0010_2000;
    localparam int NV = 6;
    localparam logic [31:0] V_ADDR [NV] = '{32'h0010_1FFC, 32'h0010_2000, 32'h0010_3FFC,
                                           32'h0010_4000, 32'h0010_2ABC, 32'h0000_0000};
    localparam logic        V_HIT  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

    logic clk = 0, rst_n = 0;
    logic diag_mode = 0, tag_rd = 0, tag_wr = 0;
    logic [7:0]  tag_index = '0;
    logic [31:0] tag_wdata = '0, tag_rdata;
    logic        tag_claim;
    logic        acc_valid = 0, acc_we = 0;
    logic [31:0] acc_addr = '0, acc_wdata = '0, acc_rdata;
    logic        acc_hit;
    logic [AW-1:0] acc_word;
    int tests = 0, fails = 0;
    logic done = 0;

    always #(CLK_P/2) clk = ~clk;

    spram_top #(.SIZE_PAGES(PAGES)) u_dut (
        .clk(clk), .rst_n(rst_n), .diag_mode(diag_mode), .tag_rd(tag_rd),
        .tag_wr(tag_wr), .tag_index(tag_index), .tag_wdata(tag_wdata),
        .tag_rdata(tag_rdata), .tag_claim(tag_claim), .acc_valid(acc_valid),
        .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_hit(acc_hit), .acc_word(acc_word), .acc_rdata(acc_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tag_read(input logic [7:0] idx, output logic [31:0] v);
        @(negedge clk); tag_rd = 1; tag_index = idx;
        @(negedge clk); tag_rd = 0; v = tag_rdata;
    endtask

    task automatic tag_write(input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk); tag_wr = 1; tag_index = idx; tag_wdata = d;
        @(negedge clk); tag_wr = 0;
    endtask

    task automatic probe(input logic [31:0] a);
        @(negedge clk); acc_valid = 0; acc_addr = a; #1;
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); acc_valid = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
        @(negedge clk); acc_valid = 0; acc_we = 0;
    endtask

    task automatic load(input logic [31:0] a, output logic [31:0] v);
        @(negedge clk); acc_valid = 1; acc_we = 0; acc_addr = a;
        @(negedge clk); acc_valid = 0; v = acc_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 / R8: reset state
        probe(32'h0000_0000);
        chk("R8 miss while disabled at base 0", {31'b0, acc_hit}, 32'h0);
        chk("R1 tag_claim idle", {31'b0, tag_claim}, 32'h0);
        diag_mode = 1;
        tag_read(8'h00, v); chk("R1 R3 base word after reset", v, 32'h0);
        tag_read(8'h08, v); chk("R1 R4 size word in bytes", v, 32'(PAGES * 4096));
        tag_read(8'h04, v); chk("R5 unused index reads zero", v, 32'h0);
        tag_read(8'h08, v);
        // R2: blocked path
        diag_mode = 0;
        tag_read(8'h00, v); chk("R2 read blocked keeps value", v, 32'(PAGES * 4096));
        @(negedge clk); tag_wr = 1; tag_index = 8'h00; tag_wdata = BASE | 32'h80; #1;
        chk("R2 tag_claim low when blocked", {31'b0, tag_claim}, 32'h0);
        @(negedge clk); tag_wr = 0;
        probe(BASE); chk("R2 blocked write leaves disabled", {31'b0, acc_hit}, 32'h0);
        diag_mode = 1;
        tag_read(8'h00, v); chk("R2 base unchanged after blocked write", v, 32'h0);
        // R6: misaligned base is masked
        tag_write(8'h00, 32'h0010_3080);
        tag_read(8'h00, v); chk("R6 R3 aligned base with enable", v, BASE | 32'h80);
        tag_write(8'h10, 32'h0);
        tag_read(8'h00, v); chk("R11 write to unused index ignored", v, BASE | 32'h80);
        // R9: window table
        for (int i = 0; i < NV; i++) begin
            probe(V_ADDR[i]);
            chk("R9 window hit", {31'b0, acc_hit}, {31'b0, V_HIT[i]});
            if (V_HIT[i])
                chk("R9 word index", 32'(acc_word), (V_ADDR[i] - BASE) >> 2);
        end
        // R10: store/load, miss store gated
        store(32'h0010_2010, 32'hCAFE_F00D);
        load(32'h0010_2010, v); chk("R10 load after store", v, 32'hCAFE_F00D);
        store(32'h0010_0010, 32'h1234_5678);
        load(32'h0010_2010, v); chk("R10 miss store has no effect", v, 32'hCAFE_F00D);
        store(32'h0010_3FFC, 32'hA5A5_0001);
        load(32'h0010_3FFC, v); chk("R10 last word", v, 32'hA5A5_0001);
        // R7: size write only touches enable
        tag_write(8'h08, 32'hFFFF_F000);
        tag_read(8'h08, v); chk("R7 size fixed, enable cleared", v, 32'(PAGES * 4096));
        probe(BASE); chk("R8 no hit after disable", {31'b0, acc_hit}, 32'h0);
        tag_write(8'h08, 32'h0000_0080);
        tag_read(8'h00, v); chk("R7 enable via size word", v, BASE | 32'h80);
        probe(BASE); chk("R9 hit after re-enable", {31'b0, acc_hit}, 32'h1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule